// File: doc/BRIEF.md
# Banked Register Address Decoder

This block sits between a register bank's bus port and its storage. On every rising clock edge it captures a word address and separate read and write enables. From those captured values it decodes, within the same cycle, which physical storage word a write strobe goes to. It also returns the read data for the addressed word, flags whether the access is acknowledged, and pulses a read-select line for registers whose contents change when read. The storage itself, the meaning of the fields and the bus handshake all live outside this block. The block receives the current contents of every physical register as one flat vector.

Registers wider than a bus word span consecutive word addresses, and each word exposes one equal slice of the register. One logical register is banked: its two addresses lead to one of three physical copies. The copy is picked at run time by a two-bit selector field that lives in the mode register. A selector value with no copy assigned gives no acknowledgement.

The decoder answers only inside its own area, which is set by the upper address bits. Outside that area it passes read data and the read acknowledgement through from a downstream stage, and it never acknowledges a write.

Top module: `regbank_decoder`

## Requirements
- R1: Address, read enable and write enable are captured on the rising clock edge. An active-low asynchronous reset clears them to address 0 with both enables low. Every output is a combinational function of the captured values and of the live storage and pass-through inputs, so a change on `addr_i` shows at the outputs only after the next rising edge.
- R2: The area is hit when address bits [5:4] equal 1, and the local word address is bits [3:0]. The local map is:
  - mode at 0, 8 bits, read/write;
  - wide at 1 and 2, 12 bits, read/write;
  - status at 3 and 4, 16 bits, read-only;
  - kick at 5, 8 bits, write-only;
  - banked at 6 and 7, 16 bits, read/write.
  `phys_q_i` packs mode in [7:0], wide in [19:8], status in [35:20], kick in [43:36], and banked copies 0, 1 and 2 in [59:44], [75:60] and [91:76]. Word w of a register reads slice bits [w*S +: S], where S is the register width divided by its word count. Every readable mapped word gives `rd_ok_o`=1.
- R3: A slice narrower than the bus word (the 6-bit slices of wide) is zero-extended to 8 bits on read.
- R4: The write-only word reads as 0 with `rd_ok_o`=0, while `wr_ok_o`=1.
- R5: A local address from 8 to 15 gives `rd_data_o`=0, `rd_ok_o`=0, `wr_ok_o`=0 and no strobes.
- R6: With write enable captured, exactly one `wr_sel_o` bit rises, for the addressed writable word, and all others stay low. Without it, all stay low. The `wr_sel_o` bit order is: mode 0, wide words 1–2, status 3–4 (never driven), kick 5, banked copy c word w at 6+2c+w. Read-only words give `wr_ok_o`=0.
- R7: The selector is mode bits [1:0]. Codes 0, 1 and 3 route the banked words to copies 0, 1 and 2, with `rd_ok_o`=1 and `wr_ok_o`=1.
- R8: Selector code 2 makes the banked words read 0, with `rd_ok_o`=0, `wr_ok_o`=0 and no write strobe.
- R9: A banked write strobe reaches only the word of the selected copy. The other copies' strobes stay low.
- R10: `rd_sel_o` bit k (k = local word address) rises only for the status words 3 and 4, and only while the read enable is captured with that word decoded inside the area. At most one bit is high at a time.
- R11: Outside the area, `rd_data_o` and `rd_ok_o` equal `chain_rd_data_i` and `chain_rd_ok_i`, `wr_ok_o`=0, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Word address |
| rd_en_i | input | 1 | Read access request |
| wr_en_i | input | 1 | Write access request |
| phys_q_i | input | 92 | Current contents of all physical registers |
| chain_rd_data_i | input | 8 | Read data from the downstream stage |
| chain_rd_ok_i | input | 1 | Read acknowledge from the downstream stage |
| wr_sel_o | output | 12 | Per physical word write strobes |
| rd_sel_o | output | 8 | Read-select pulses per local word |
| rd_data_o | output | 8 | Decoded read data |
| rd_ok_o | output | 1 | Read acknowledge |
| wr_ok_o | output | 1 | Write acknowledge |

## Verification
A read and a write can both be decoded in one cycle. On the status words this raises the side-effect read pulse while the write path must refuse. On the banked words the read mux and the forwarded write strobe both depend on the same selector value. The sweep raises both enables together on every address, for every selector code including the unassigned one, and with two storage patterns. Each cycle's read data, acknowledgements and both strobe vectors are compared against a model computed from the address map.

// File: rtl/regbank_dec_pkg.sv
package regbank_dec_pkg;

   localparam int ACC_RW = 0;
   localparam int ACC_RO = 1;
   localparam int ACC_WO = 2;

   // logical register map, in address order
   localparam int N_LREG = 5;
   localparam int LREG_WIDTH [N_LREG] = '{8, 12, 16, 8, 16};
   localparam int LREG_WORDS [N_LREG] = '{1, 2, 2, 1, 2};
   localparam int LREG_ACC   [N_LREG] = '{ACC_RW, ACC_RW, ACC_RO, ACC_WO, ACC_RW};
   localparam int LREG_RDFX  [N_LREG] = '{0, 0, 1, 0, 0};
   localparam int LREG_NBANK [N_LREG] = '{1, 1, 1, 1, 3};

   // selector codes naming each physical copy of a banked register
   localparam int MAX_BANK = 3;
   localparam int BANK_CODE [MAX_BANK] = '{0, 1, 3};

   // selector field location
   localparam int SEL_REG = 0;
   localparam int SEL_LSB = 0;
   localparam int SEL_W   = 2;

   function automatic int word_base(input int r);
      int s = 0;
      for (int j = 0; j < r; j++) s += LREG_WORDS[j];
      return s;
   endfunction

   function automatic int bit_base(input int r);
      int s = 0;
      for (int j = 0; j < r; j++) s += LREG_NBANK[j] * LREG_WIDTH[j];
      return s;
   endfunction

   function automatic int wsel_base(input int r);
      int s = 0;
      for (int j = 0; j < r; j++) s += LREG_NBANK[j] * LREG_WORDS[j];
      return s;
   endfunction

   localparam int N_AWORDS  = word_base(N_LREG);
   localparam int PHYS_BITS = bit_base(N_LREG);
   localparam int N_WSEL    = wsel_base(N_LREG);

endpackage

// File: rtl/regbank_addr_stage.sv
module regbank_addr_stage #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rd_q,
   output logic              wr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         addr_q <= addr_i;
         rd_q   <= rd_en_i;
         wr_q   <= wr_en_i;
      end
   end

endmodule

// File: rtl/regbank_bank_route.sv
module regbank_bank_route
   import regbank_dec_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int WORDS = 2,
   parameter int NBANK = 1
) (
   input  logic [SEL_W-1:0]       sel_i,
   input  logic [NBANK*WIDTH-1:0] phys_i,
   input  logic [WORDS-1:0]       wsel_i,
   output logic [WIDTH-1:0]       val_o,
   output logic                   ok_o,
   output logic [NBANK*WORDS-1:0] wsel_o
);

   if (NBANK > MAX_BANK) begin : g_bad_nbank
      $error("regbank_bank_route: NBANK exceeds the code table");
   end

   if (NBANK == 1) begin : g_plain
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign val_o  = phys_i;
      assign ok_o   = 1'b1;
      assign wsel_o = wsel_i;
   end else begin : g_banked
      always_comb begin
         val_o  = '0;
         ok_o   = 1'b0;
         wsel_o = '0;
         for (int b = 0; b < NBANK; b++) begin
            if (sel_i == SEL_W'(BANK_CODE[b])) begin
               val_o                     = phys_i[b*WIDTH +: WIDTH];
               ok_o                      = 1'b1;
               wsel_o[b*WORDS +: WORDS]  = wsel_i;
            end
         end
      end
   end

endmodule

// File: rtl/regbank_word_port.sv
module regbank_word_port
   import regbank_dec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LOC_W  = 4,
   parameter int BASE   = 0,
   parameter int WORDS  = 1,
   parameter int WIDTH  = 8,
   parameter int ACC    = 0,
   parameter int RDFX   = 0
) (
   input  logic              area_hit_i,
   input  logic [LOC_W-1:0]  loc_i,
   input  logic              rd_q_i,
   input  logic              wr_q_i,
   input  logic [WIDTH-1:0]  val_i,
   input  logic              ok_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_ok_o,
   output logic              wr_ok_o,
   output logic [WORDS-1:0]  wsel_o,
   output logic [WORDS-1:0]  rsel_o
);

   localparam int SLICE = WIDTH / WORDS;

   if (SLICE * WORDS != WIDTH) begin : g_bad_split
      $error("regbank_word_port: width is not a multiple of word count");
   end
   if (SLICE > DATA_W) begin : g_bad_slice
      $error("regbank_word_port: slice wider than bus word");
   end

   logic [WORDS-1:0] hit;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int ADR = BASE + w;
      assign hit[w]    = area_hit_i && (loc_i == LOC_W'(ADR));
      assign wsel_o[w] = wr_q_i && hit[w] && (ACC != ACC_RO);
      assign rsel_o[w] = rd_q_i && hit[w] && (RDFX != 0);
   end

   always_comb begin
      rd_data_o = '0;
      rd_ok_o   = 1'b0;
      wr_ok_o   = 1'b0;
      for (int w = 0; w < WORDS; w++) begin
         if (hit[w]) begin
            if (ACC != ACC_WO) begin
               rd_data_o = DATA_W'(val_i[w*SLICE +: SLICE]);
               rd_ok_o   = ok_i;
            end
            if (ACC != ACC_RO) wr_ok_o = ok_i;
         end
      end
   end

endmodule

// File: rtl/regbank_decoder.sv
module regbank_decoder
   import regbank_dec_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 6,
   parameter int AREA_W  = 2,
   parameter int AREA_ID = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 rd_en_i,
   input  logic                 wr_en_i,
   input  logic [PHYS_BITS-1:0] phys_q_i,
   input  logic [DATA_W-1:0]    chain_rd_data_i,
   input  logic                 chain_rd_ok_i,
   output logic [N_WSEL-1:0]    wr_sel_o,
   output logic [N_AWORDS-1:0]  rd_sel_o,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 rd_ok_o,
   output logic                 wr_ok_o
);

   localparam int LOC_W = ADDR_W - AREA_W;

   if (LOC_W < $clog2(N_AWORDS)) begin : g_bad_loc
      $error("regbank_decoder: local address too narrow for the map");
   end
   if (AREA_W > 0 && AREA_ID >= (1 << AREA_W)) begin : g_bad_area
      $error("regbank_decoder: area id does not fit");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic              wr_q;

   regbank_addr_stage #(.ADDR_W(ADDR_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr_i),
      .rd_en_i (rd_en_i),
      .wr_en_i (wr_en_i),
      .addr_q  (addr_q),
      .rd_q    (rd_q),
      .wr_q    (wr_q)
   );

   logic             area_hit;
   logic [LOC_W-1:0] loc;

   if (AREA_W > 0) begin : g_area
      assign area_hit = (addr_q[ADDR_W-1 -: AREA_W] == AREA_W'(AREA_ID));
   end else begin : g_flat
      assign area_hit = 1'b1;
   end
   assign loc = addr_q[LOC_W-1:0];

   logic [SEL_W-1:0] sel;
   assign sel = phys_q_i[bit_base(SEL_REG) + SEL_LSB +: SEL_W];

   logic [DATA_W-1:0] rdd_c [N_LREG];
   logic [N_LREG-1:0] rok_c;
   logic [N_LREG-1:0] wok_c;

   for (genvar r = 0; r < N_LREG; r++) begin : g_reg
      localparam int W  = LREG_WIDTH[r];
      localparam int NW = LREG_WORDS[r];
      localparam int NB = LREG_NBANK[r];

      logic [W-1:0]  val;
      logic          bank_ok;
      logic [NW-1:0] wsel_log;

      regbank_word_port #(
         .DATA_W (DATA_W),
         .LOC_W  (LOC_W),
         .BASE   (word_base(r)),
         .WORDS  (NW),
         .WIDTH  (W),
         .ACC    (LREG_ACC[r]),
         .RDFX   (LREG_RDFX[r])
      ) u_port (
         .area_hit_i (area_hit),
         .loc_i      (loc),
         .rd_q_i     (rd_q),
         .wr_q_i     (wr_q),
         .val_i      (val),
         .ok_i       (bank_ok),
         .rd_data_o  (rdd_c[r]),
         .rd_ok_o    (rok_c[r]),
         .wr_ok_o    (wok_c[r]),
         .wsel_o     (wsel_log),
         .rsel_o     (rd_sel_o[word_base(r) +: NW])
      );

      regbank_bank_route #(
         .WIDTH (W),
         .WORDS (NW),
         .NBANK (NB)
      ) u_route (
         .sel_i  (sel),
         .phys_i (phys_q_i[bit_base(r) +: NB*W]),
         .wsel_i (wsel_log),
         .val_o  (val),
         .ok_o   (bank_ok),
         .wsel_o (wr_sel_o[wsel_base(r) +: NB*NW])
      );
   end

   logic [DATA_W-1:0] local_data;

   always_comb begin
      local_data = '0;
      for (int r = 0; r < N_LREG; r++) local_data |= rdd_c[r];
   end

   assign rd_data_o = area_hit ? local_data : chain_rd_data_i;
   assign rd_ok_o   = area_hit ? (|rok_c) : chain_rd_ok_i;
   assign wr_ok_o   = |wok_c;

endmodule

// File: rtl/regbank_decoder_chk.sv
module regbank_decoder_chk
   import regbank_dec_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 6,
   parameter int AREA_W  = 2,
   parameter int AREA_ID = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr_i,
   input logic                rd_en_i,
   input logic                wr_en_i,
   input logic [DATA_W-1:0]   chain_rd_data_i,
   input logic                chain_rd_ok_i,
   input logic [N_WSEL-1:0]   wr_sel_o,
   input logic [N_AWORDS-1:0] rd_sel_o,
   input logic [DATA_W-1:0]   rd_data_o,
   input logic                rd_ok_o,
   input logic                wr_ok_o
);

   localparam int LOC_W = ADDR_W - AREA_W;

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   a_r6_wsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel_o));

   a_r10_rsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel_o));

   a_r6_wsel_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_sel_o) |-> wr_ok_o);

   a_r6_wsel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (|wr_sel_o)) |-> $past(wr_en_i));

   a_r10_rsel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (|rd_sel_o)) |-> $past(rd_en_i));

   if (AREA_W > 0) begin : g_area_chk
      a_r11_area_miss: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && ($past(addr_i[ADDR_W-1 -: AREA_W]) != AREA_W'(AREA_ID)))
         |-> (!wr_ok_o && (wr_sel_o == '0) && (rd_sel_o == '0)
              && (rd_data_o == chain_rd_data_i) && (rd_ok_o == chain_rd_ok_i)));

      a_r5_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && ($past(addr_i[ADDR_W-1 -: AREA_W]) == AREA_W'(AREA_ID))
                 && (int'($past(addr_i[LOC_W-1:0])) >= N_AWORDS))
         |-> (!wr_ok_o && !rd_ok_o && (rd_data_o == '0) && (wr_sel_o == '0)));
   end

endmodule

bind regbank_decoder regbank_decoder_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .AREA_W  (AREA_W),
   .AREA_ID (AREA_ID)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .addr_i          (addr_i),
   .rd_en_i         (rd_en_i),
   .wr_en_i         (wr_en_i),
   .chain_rd_data_i (chain_rd_data_i),
   .chain_rd_ok_i   (chain_rd_ok_i),
   .wr_sel_o        (wr_sel_o),
   .rd_sel_o        (rd_sel_o),
   .rd_data_o       (rd_data_o),
   .rd_ok_o         (rd_ok_o),
   .wr_ok_o         (wr_ok_o)
);

// File: tb/regbank_decoder_tb_top.sv
`timescale 1ns/1ps
module regbank_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [91:0] phys = '0;
   logic [7:0]  chain_d = 8'h5A;
   logic        chain_ok = 1'b1;
   logic [11:0] wr_sel;
   logic [7:0]  rd_sel;
   logic [7:0]  rd_data;
   logic        rd_ok;
   logic        wr_ok;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   regbank_decoder dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .addr_i          (addr),
      .rd_en_i         (rd_en),
      .wr_en_i         (wr_en),
      .phys_q_i        (phys),
      .chain_rd_data_i (chain_d),
      .chain_rd_ok_i   (chain_ok),
      .wr_sel_o        (wr_sel),
      .rd_sel_o        (rd_sel),
      .rd_data_o       (rd_data),
      .rd_ok_o         (rd_ok),
      .wr_ok_o         (wr_ok)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s addr=%0d actual=%0h expected=%0h", req, what, addr, act, exp);
      end
   endtask

   // reference model of the address map
   task automatic model(input logic [5:0] a, input logic en, input logic [91:0] p,
                        input logic [7:0] cd, input logic cok,
                        output logic [7:0] d, output logic ok, output logic wok,
                        output logic [11:0] ws, output logic [7:0] rs,
                        output string tag, output string wtag);
      int la;
      int cp;
      d = 8'h00; ok = 1'b0; wok = 1'b0; ws = '0; rs = '0;
      tag = "R5"; wtag = "R6";
      la = int'(a[3:0]);
      if (a[5:4] != 2'd1) begin
         d = cd; ok = cok; tag = "R11"; wtag = "R11";
      end else begin
         case (la)
            0: begin d = p[7:0]; ok = 1; wok = 1; ws[0] = en; tag = "R2"; end
            1: begin d = {2'b00, p[13:8]};  ok = 1; wok = 1; ws[1] = en; tag = "R3"; end
            2: begin d = {2'b00, p[19:14]}; ok = 1; wok = 1; ws[2] = en; tag = "R3"; end
            3: begin d = p[27:20]; ok = 1; rs[3] = en; tag = "R2"; end
            4: begin d = p[35:28]; ok = 1; rs[4] = en; tag = "R2"; end
            5: begin wok = 1; ws[5] = en; tag = "R4"; end
            6, 7: begin
               case (p[1:0])
                  2'd0: cp = 0;
                  2'd1: cp = 1;
                  2'd3: cp = 2;
                  default: cp = -1;
               endcase
               if (cp >= 0) begin
                  d = p[44 + 16*cp + 8*(la-6) +: 8];
                  ok = 1; wok = 1;
                  ws[6 + 2*cp + (la-6)] = en;
                  tag = "R7"; wtag = "R9";
               end else begin
                  tag = "R8"; wtag = "R8";
               end
            end
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0]  ed;
      logic        eok, ewok;
      logic [11:0] ews;
      logic [7:0]  ers;
      string       tg, wtg;
      logic [95:0] seedv;

      // R1: reset state (captured address 0 lies outside the area)
      #1;
      check("R1", "reset wr_sel", 32'(wr_sel), 0);
      check("R1", "reset rd_sel", 32'(rd_sel), 0);
      check("R1", "reset wr_ok", 32'(wr_ok), 0);
      check("R1", "reset rd_data", 32'(rd_data), 32'h5A);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: address change takes effect only after the next edge
      @(negedge clk);
      addr = 6'd16; rd_en = 1'b1; wr_en = 1'b0;
      phys = '0; phys[7:0] = 8'hA5; chain_d = 8'h3C; chain_ok = 1'b0;
      #1;
      check("R1", "before edge rd_data", 32'(rd_data), 32'h3C);
      check("R1", "before edge rd_ok", 32'(rd_ok), 0);
      @(negedge clk);
      check("R1", "after edge rd_data", 32'(rd_data), 32'hA5);
      check("R1", "after edge rd_ok", 32'(rd_ok), 1);
      check("R6", "read-only access wr_sel", 32'(wr_sel), 0);

      // full sweep: storage pattern x selector code x enables x address
      seedv = {32'hC3A5_96E1, 32'h1F2E_3D4C, 32'h5B6A_7988};
      for (int pat = 0; pat < 2; pat++) begin
         for (int code = 0; code < 4; code++) begin
            for (int en = 0; en < 2; en++) begin
               for (int a = 0; a < 64; a++) begin
                  @(negedge clk);
                  addr  = 6'(a);
                  rd_en = en[0];
                  wr_en = en[0];
                  phys  = (pat == 0) ? seedv[91:0] : ~seedv[91:0];
                  phys[1:0] = code[1:0];
                  chain_d  = 8'(a*37 + pat*11 + code);
                  chain_ok = a[0] ^ pat[0];
                  @(negedge clk);
                  model(addr, en[0], phys, chain_d, chain_ok, ed, eok, ewok, ews, ers, tg, wtg);
                  check(tg, "rd_data", 32'(rd_data), 32'(ed));
                  check(tg, "rd_ok", 32'(rd_ok), 32'(eok));
                  check(tg, "wr_ok", 32'(wr_ok), 32'(ewok));
                  check(wtg, "wr_sel", 32'(wr_sel), 32'(ews));
                  check("R10", "rd_sel", 32'(rd_sel), 32'(ers));
               end
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule